// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides which operating mode a small microcontroller is in (active, sleep, subsleep or standby) and turns that mode into registered control outputs. These are a system oscillator enable, a CPU clock enable, a peripheral clock enable, a high-impedance control for the I/O output drivers, and one-cycle reset strobes for two peripheral groups. Software enters a low-power mode by pulsing a sleep request together with a two-bit mode selector. The controller returns to active mode when an enabled interrupt arrives and the global interrupt mask is clear. On that return it raises a one-cycle wake pulse, which tells the CPU to start interrupt exception handling.

In sleep mode the CPU clock is stopped but the oscillator keeps running. Peripherals then receive a clock-enable pulse whose rate is set by a three-bit divider select. In subsleep and standby modes the oscillator and the CPU are both stopped. In those two modes only the external interrupt lines can end the mode. Standby also places the I/O output drivers in high impedance. Either the synchronous system reset or a low level on the reset pin brings the controller back to active mode from any mode.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst` is high or `res_n` is low at a clock edge, the next state is active mode from any mode, including sleep. In that state `mode_o`=0, `osc_en`=1, `cpu_clk_en`=1, `per_clk_en`=1, `io_hiz`=0, `wake_pulse`=0 and `per_rst`=0.
- R2: A one-cycle `sleep_req` in active mode changes the mode at the next edge. `mode_sel` 00 selects sleep (`mode_o`=1), 01 selects subsleep (`mode_o`=2) and 10 selects standby (`mode_o`=3). All outputs change at the same edge as `mode_o`.
- R3: In sleep mode `cpu_clk_en`=0, `osc_en`=1 and `io_hiz`=0.
- R4: In sleep mode `per_clk_en` pulses on the first sleep cycle and then once every 2^N cycles, where N is `div_sel`. N=0 gives a pulse on every cycle.
- R5: In subsleep and standby modes `osc_en`, `cpu_clk_en` and `per_clk_en` are all 0.
- R6: `io_hiz` is 1 in standby mode and 0 in every other mode.
- R7: In sleep mode, a request `irq_req[i]` with `irq_en[i]`=1 while `irq_mask`=0 returns the controller to active mode at the next edge. `wake_pulse` is 1 for exactly the first active cycle.
- R8: No wake-up happens while `irq_mask`=1, or for a request whose `irq_en` bit is 0.
- R9: In subsleep and standby modes only the external lines `irq_req[N_EXT-1:0]` can wake the controller, qualified as in R7 and R8. Enabled requests on the higher-numbered lines are ignored.
- R10: `per_rst[0]` pulses for one cycle when subsleep or standby is entered. `per_rst[1]` pulses for one cycle when standby is entered.
- R11: A `sleep_req` with `mode_sel`=11 is ignored. A `sleep_req` in any mode other than active is also ignored.
- R12: In active mode `per_clk_en` stays at 1 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| res_n | input | 1 | Active-low reset pin, sampled synchronously |
| sleep_req | input | 1 | One-cycle request to enter a low-power mode |
| mode_sel | input | 2 | Target mode: 00 sleep, 01 subsleep, 10 standby, 11 ignored |
| div_sel | input | DIV_W | Peripheral clock divider exponent used in sleep mode |
| irq_req | input | N_IRQ | Interrupt requests; lines below N_EXT are external |
| irq_en | input | N_IRQ | Individual interrupt enables |
| irq_mask | input | 1 | Global interrupt mask; 1 blocks wake-up |
| mode_o | output | 2 | Current mode: 0 active, 1 sleep, 2 subsleep, 3 standby |
| osc_en | output | 1 | System oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock-enable pulse |
| io_hiz | output | 1 | Places the I/O output drivers in high impedance |
| per_rst | output | 2 | Peripheral group reset strobes |
| wake_pulse | output | 1 | One-cycle pulse that starts interrupt exception handling |

## Verification
The assertions check on every cycle that each mode produces the right clock and tri-state pattern. They also check that the wake pulse appears only on a return to active mode, that a set mask or a reserved selector keeps the mode unchanged, and that internal lines cannot end subsleep or standby. Some behaviours can only be shown by the bench's scenarios. These are the divider pulse counts for every `div_sel` value, the entry strobes on the peripheral reset outputs, the effect of the reset pin in the middle of a sleep period, and the wake-up sources that each mode accepts.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    LPM_ACTIVE   = 2'd0,
    LPM_SLEEP    = 2'd1,
    LPM_SUBSLEEP = 2'd2,
    LPM_STANDBY  = 2'd3
  } lpm_mode_e;

  function automatic logic osc_runs(input lpm_mode_e m);
    return (m == LPM_ACTIVE) || (m == LPM_SLEEP);
  endfunction
endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
  import lpm_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int N_EXT = 2
) (
  input  lpm_mode_e          mode_q,
  input  logic [N_IRQ-1:0]   irq_req,
  input  logic [N_IRQ-1:0]   irq_en,
  input  logic               irq_mask,
  output logic               wake_req
);
  logic [N_IRQ-1:0] src_ok;

  // external lines wake in every low-power mode, internal ones only in sleep
  for (genvar i = 0; i < N_IRQ; i++) begin : g_src
    if (i < N_EXT) begin : g_ext
      assign src_ok[i] = 1'b1;
    end else begin : g_int
      assign src_ok[i] = (mode_q == LPM_SLEEP);
    end
  end

  assign wake_req = !irq_mask && |(irq_req & irq_en & src_ok);
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_all,
  input  logic       sleep_req,
  input  logic [1:0] mode_sel,
  input  logic       wake_req,
  output lpm_mode_e  mode_q,
  output lpm_mode_e  mode_nxt,
  output logic       osc_en,
  output logic       cpu_clk_en,
  output logic       io_hiz,
  output logic       wake_pulse,
  output logic [1:0] per_rst
);
  always_comb begin
    mode_nxt = mode_q;
    if (mode_q == LPM_ACTIVE) begin
      if (sleep_req) begin
        case (mode_sel)
          2'b00:   mode_nxt = LPM_SLEEP;
          2'b01:   mode_nxt = LPM_SUBSLEEP;
          2'b10:   mode_nxt = LPM_STANDBY;
          default: mode_nxt = LPM_ACTIVE;
        endcase
      end
    end else if (wake_req) begin
      mode_nxt = LPM_ACTIVE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_all) begin
      mode_q     <= LPM_ACTIVE;
      osc_en     <= 1'b1;
      cpu_clk_en <= 1'b1;
      io_hiz     <= 1'b0;
      wake_pulse <= 1'b0;
      per_rst    <= 2'b00;
    end else begin
      mode_q     <= mode_nxt;
      osc_en     <= osc_runs(mode_nxt);
      cpu_clk_en <= (mode_nxt == LPM_ACTIVE);
      io_hiz     <= (mode_nxt == LPM_STANDBY);
      wake_pulse <= (mode_q != LPM_ACTIVE) && (mode_nxt == LPM_ACTIVE);
      per_rst[0] <= (mode_q != mode_nxt) &&
                    ((mode_nxt == LPM_SUBSLEEP) || (mode_nxt == LPM_STANDBY));
      per_rst[1] <= (mode_q != mode_nxt) && (mode_nxt == LPM_STANDBY);
    end
  end
endmodule

// File: rtl/lpm_per_div.sv
module lpm_per_div
  import lpm_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_all,
  input  lpm_mode_e        mode_q,
  input  lpm_mode_e        mode_nxt,
  input  logic [DIV_W-1:0] div_sel,
  output logic             per_clk_en
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt, div_mask;

  always_comb begin
    div_mask = '0;
    for (int b = 0; b < CNT_W; b++) begin
      if (b < int'(div_sel)) div_mask[b] = 1'b1;
    end
    cnt_nxt = ((mode_q == LPM_SLEEP) && (mode_nxt == LPM_SLEEP)) ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk) begin
    if (rst_all) begin
      cnt_q      <= '0;
      per_clk_en <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      if (mode_nxt == LPM_SLEEP) per_clk_en <= ((cnt_nxt & div_mask) == '0);
      else                       per_clk_en <= (mode_nxt == LPM_ACTIVE);
    end
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int N_EXT = 2,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_n,
  input  logic             sleep_req,
  input  logic [1:0]       mode_sel,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             irq_mask,
  output logic [1:0]       mode_o,
  output logic             osc_en,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             io_hiz,
  output logic [1:0]       per_rst,
  output logic             wake_pulse
);
  logic      rst_all;
  logic      wake_req;
  lpm_mode_e mode_q, mode_nxt;

  assign rst_all = rst || !res_n;
  assign mode_o  = mode_q;

  lpm_wake_qual #(.N_IRQ(N_IRQ), .N_EXT(N_EXT)) u_wake (
    .mode_q   (mode_q),
    .irq_req  (irq_req),
    .irq_en   (irq_en),
    .irq_mask (irq_mask),
    .wake_req (wake_req)
  );

  lpm_mode_fsm u_fsm (
    .clk        (clk),
    .rst_all    (rst_all),
    .sleep_req  (sleep_req),
    .mode_sel   (mode_sel),
    .wake_req   (wake_req),
    .mode_q     (mode_q),
    .mode_nxt   (mode_nxt),
    .osc_en     (osc_en),
    .cpu_clk_en (cpu_clk_en),
    .io_hiz     (io_hiz),
    .wake_pulse (wake_pulse),
    .per_rst    (per_rst)
  );

  lpm_per_div #(.DIV_W(DIV_W)) u_div (
    .clk        (clk),
    .rst_all    (rst_all),
    .mode_q     (mode_q),
    .mode_nxt   (mode_nxt),
    .div_sel    (div_sel),
    .per_clk_en (per_clk_en)
  );
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int N_IRQ = 8,
  parameter int N_EXT = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             res_n,
  input logic             sleep_req,
  input logic [1:0]       mode_sel,
  input logic [N_IRQ-1:0] irq_req,
  input logic [N_IRQ-1:0] irq_en,
  input logic             irq_mask,
  input logic [1:0]       mode_o,
  input logic             osc_en,
  input logic             cpu_clk_en,
  input logic             per_clk_en,
  input logic             io_hiz,
  input logic             wake_pulse
);
  logic [N_IRQ-1:0] ext_lines;
  assign ext_lines = N_IRQ'((1 << N_EXT) - 1);

  // R3
  sleep_clocks_chk: assert property (@(posedge clk) disable iff (rst || !res_n)
    (mode_o == 2'd1) |-> (osc_en && !cpu_clk_en && !io_hiz));

  // R5
  deep_clocks_chk: assert property (@(posedge clk) disable iff (rst || !res_n)
    (mode_o[1]) |-> (!osc_en && !cpu_clk_en && !per_clk_en));

  // R6
  hiz_only_standby_chk: assert property (@(posedge clk) disable iff (rst || !res_n)
    io_hiz == (mode_o == 2'd3));

  // R7
  wake_on_return_chk: assert property (@(posedge clk) disable iff (rst || !res_n)
    wake_pulse |-> ((mode_o == 2'd0) && ($past(mode_o) != 2'd0)));

  // R8
  mask_holds_chk: assert property (@(posedge clk) disable iff (rst || !res_n)
    ((mode_o != 2'd0) && irq_mask) |=> (mode_o != 2'd0));

  // R9
  deep_ext_only_chk: assert property (@(posedge clk) disable iff (rst || !res_n)
    (mode_o[1] && ((irq_req & irq_en & ext_lines) == '0)) |=> (mode_o != 2'd0));

  // R11
  reserved_sel_chk: assert property (@(posedge clk) disable iff (rst || !res_n)
    ((mode_o == 2'd0) && sleep_req && (mode_sel == 2'b11)) |=> (mode_o == 2'd0));

  // R12
  active_per_chk: assert property (@(posedge clk) disable iff (rst || !res_n)
    (mode_o == 2'd0) |-> (per_clk_en && cpu_clk_en));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.N_IRQ(N_IRQ), .N_EXT(N_EXT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .res_n      (res_n),
  .sleep_req  (sleep_req),
  .mode_sel   (mode_sel),
  .irq_req    (irq_req),
  .irq_en     (irq_en),
  .irq_mask   (irq_mask),
  .mode_o     (mode_o),
  .osc_en     (osc_en),
  .cpu_clk_en (cpu_clk_en),
  .per_clk_en (per_clk_en),
  .io_hiz     (io_hiz),
  .wake_pulse (wake_pulse)
);

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_IRQ = 8;
  localparam int N_EXT = 2;
  localparam int DIV_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             res_n = 1'b1;
  logic             sleep_req = 1'b0;
  logic [1:0]       mode_sel = 2'b00;
  logic [DIV_W-1:0] div_sel = '0;
  logic [N_IRQ-1:0] irq_req = '0;
  logic [N_IRQ-1:0] irq_en = '0;
  logic             irq_mask = 1'b0;
  logic [1:0]       mode_o;
  logic             osc_en, cpu_clk_en, per_clk_en, io_hiz, wake_pulse;
  logic [1:0]       per_rst;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_ctrl #(.N_IRQ(N_IRQ), .N_EXT(N_EXT), .DIV_W(DIV_W)) u0 (
    .clk(clk), .rst(rst), .res_n(res_n), .sleep_req(sleep_req),
    .mode_sel(mode_sel), .div_sel(div_sel), .irq_req(irq_req),
    .irq_en(irq_en), .irq_mask(irq_mask), .mode_o(mode_o),
    .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .io_hiz(io_hiz), .per_rst(per_rst), .wake_pulse(wake_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic enter(input logic [1:0] sel);
    mode_sel  = sel;
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
  endtask

  task automatic clear_irq();
    irq_req = '0; irq_en = '0; irq_mask = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    step();
    chk("R1 mode", mode_o, 0);
    chk("R1 osc", osc_en, 1);
    chk("R1 cpu", cpu_clk_en, 1);
    chk("R1 per", per_clk_en, 1);
    chk("R1 hiz", io_hiz, 0);
    chk("R1 wake", wake_pulse, 0);
    chk("R1 per_rst", per_rst, 0);
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R12 active per_clk_en", per_clk_en, 1);
    end
  endtask

  task automatic t_sleep_div();
    for (int n = 0; n < 8; n++) begin
      int cnt;
      div_sel = DIV_W'(n);
      enter(2'b00);
      chk("R2 sleep mode", mode_o, 1);
      chk("R3 sleep cpu", cpu_clk_en, 0);
      chk("R3 sleep osc", osc_en, 1);
      chk("R3 sleep hiz", io_hiz, 0);
      cnt = 0;
      for (int k = 0; k < 32; k++) begin
        cnt += int'(per_clk_en);
        step();
      end
      chk("R4 pulse count", cnt, (n <= 5) ? (32 >> n) : 1);
      irq_req = 8'h01; irq_en = 8'h01;
      step();
      chk("R7 wake mode", mode_o, 0);
      chk("R7 wake pulse", wake_pulse, 1);
      chk("R7 cpu on", cpu_clk_en, 1);
      clear_irq();
      step();
      chk("R7 wake one cycle", wake_pulse, 0);
    end
  endtask

  task automatic t_mask();
    enter(2'b00);
    irq_mask = 1'b1; irq_req = '1; irq_en = '1;
    step(); step(); step();
    chk("R8 masked stays", mode_o, 1);
    chk("R8 masked no wake", wake_pulse, 0);
    irq_mask = 1'b0; irq_en = '0;
    step(); step();
    chk("R8 disabled stays", mode_o, 1);
    irq_req = 8'h10; irq_en = 8'h10;
    step();
    chk("R7 internal wakes sleep", mode_o, 0);
    chk("R7 internal wake pulse", wake_pulse, 1);
    clear_irq();
    step();
  endtask

  task automatic t_subsleep();
    enter(2'b01);
    chk("R2 subsleep mode", mode_o, 2);
    chk("R5 sub osc", osc_en, 0);
    chk("R5 sub cpu", cpu_clk_en, 0);
    chk("R5 sub per", per_clk_en, 0);
    chk("R10 sub strobe", per_rst, 1);
    chk("R6 sub hiz", io_hiz, 0);
    step();
    chk("R10 sub strobe ends", per_rst, 0);
    irq_req = 8'h80; irq_en = 8'h80;
    step(); step();
    chk("R9 internal ignored", mode_o, 2);
    irq_req = 8'h02; irq_en = 8'h02;
    step();
    chk("R9 external wakes", mode_o, 0);
    chk("R9 wake pulse", wake_pulse, 1);
    clear_irq();
    step();
  endtask

  task automatic t_standby();
    enter(2'b10);
    chk("R2 standby mode", mode_o, 3);
    chk("R6 standby hiz", io_hiz, 1);
    chk("R10 standby strobe", per_rst, 3);
    chk("R5 standby osc", osc_en, 0);
    chk("R5 standby per", per_clk_en, 0);
    step();
    chk("R10 standby strobe ends", per_rst, 0);
    enter(2'b00);
    chk("R11 req in standby ignored", mode_o, 3);
    irq_req = 8'h01; irq_en = 8'h01;
    step();
    chk("R9 standby ext wake", mode_o, 0);
    chk("R6 hiz released", io_hiz, 0);
    chk("R7 standby wake pulse", wake_pulse, 1);
    clear_irq();
    step();
  endtask

  task automatic t_reserved();
    enter(2'b11);
    chk("R11 reserved sel mode", mode_o, 0);
    chk("R11 reserved sel cpu", cpu_clk_en, 1);
    chk("R11 reserved sel strobe", per_rst, 0);
  endtask

  task automatic t_respin();
    div_sel = 3'd2;
    enter(2'b00);
    step(); step();
    res_n = 1'b0;
    step();
    res_n = 1'b1;
    chk("R1 pin reset mode", mode_o, 0);
    chk("R1 pin reset cpu", cpu_clk_en, 1);
    chk("R1 pin reset wake", wake_pulse, 0);
    chk("R1 pin reset per", per_clk_en, 1);
    step();
    chk("R1 stays active", mode_o, 0);
  endtask

  initial begin
    t_reset();
    t_sleep_div();
    t_mask();
    t_subsleep();
    t_standby();
    t_reserved();
    t_respin();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule